// File: doc/BRIEF.md
# DMA Channel Request and Acknowledge Handshake

This block qualifies the transfer requests of one DMA channel and drives that channel's acknowledge pin. A five-bit control field selects the request source. The source is either an internal auto-request or a module request. A module request comes from an external request pin or from a request strobe of an on-chip serial unit. The same field sets the polarity of the request pin, whether that pin is detected by level or by edge, the polarity of the acknowledge pin, and which bus phase the acknowledge pin marks.

A DMA bus engine reports its read phase and its write phase and whether the channel runs in single-address mode. In dual-address mode the acknowledge bit picks the read phase or the write phase. In single-address mode the same bit is the transfer direction flag given to the engine. The external request pin passes through a two-stage synchronizer before detection. The qualified request is gated by a channel enable.

The control field is written through a write strobe and a data port whose bits keep their positions 9 to 5. The standby input clears the field. While the module-stop input is high, writes are dropped and the field keeps its value.

Top module: `dma_req_ack`

## Requirements
- R1: After reset every control bit is 0. With the request pin high, serReq low and no bus phase, xferReq is 0, dackPin is 1 and devToMem is 0.
- R2: With the auto bit (bit 9) set to 1, xferReq equals chanEn whatever the request pin does.
- R3: With the edge bit (bit 6) at 0, xferReq rises after the second clock edge following the pin entering its active level. It falls after the second edge following the pin leaving that level.
- R4: With bit 6 at 1, entering the active level gives one xferReq pulse of exactly one cycle, after the second edge. Holding the active level gives no further pulse.
- R5: The request polarity bit (bit 5) makes the pin active-high when 1 and active-low when 0.
- R6: In module mode (bit 9 at 0), serReq high drives xferReq high in the same cycle while chanEn is high.
- R7: chanEn low forces xferReq to 0 in every mode.
- R8: The acknowledge polarity bit (bit 7) makes dackPin active-high when 1 and active-low when 0. With no bus phase in progress, dackPin rests at the inactive level.
- R9: In dual-address mode (singleAddr 0), bit 8 at 0 asserts dackPin during rdPhase only. Bit 8 at 1 asserts it during wrPhase only.
- R10: In single-address mode, devToMem equals bit 8 and dackPin is asserted during either phase. In dual-address mode devToMem is 0.
- R11: standbyIn high clears every control bit at the next clock edge.
- R12: A write made while modStopIn is high is ignored, and the control bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| standbyIn | input | 1 | Standby state; clears the control field |
| modStopIn | input | 1 | Module stop; holds the field and blocks writes |
| cfgWe | input | 1 | Control field write strobe |
| cfgWrData | input | 5 | Control bits, indexed 9 down to 5 |
| chanEn | input | 1 | Channel enable |
| dreqPin | input | 1 | External request pin, asynchronous |
| serReq | input | 1 | Request strobe from the serial unit |
| rdPhase | input | 1 | Engine is in a data read cycle |
| wrPhase | input | 1 | Engine is in a data write cycle |
| singleAddr | input | 1 | Channel runs in single-address mode |
| xferReq | output | 1 | Qualified transfer request to the engine |
| dackPin | output | 1 | Acknowledge pin |
| devToMem | output | 1 | Single-address direction, 1 means device to memory |

## Verification
dackPin, devToMem and the serReq, auto and enable paths are combinational, so they are due in the same cycle as their stimulus. A new control field takes effect after the edge that writes it. Pin-driven requests appear after the second edge, and edge-mode pulses fall after the third. The bench drives inputs just after a rising edge and steps the exact number of edges for each result. It then queues the expected triple of outputs. A monitor compares that triple on the following falling edge, so every check sits at its due cycle and away from the clock edge.

// File: rtl/dra_pkg.sv
package dra_pkg;
  // Field positions inside the control word.
  localparam int AUTO_BIT   = 9;
  localparam int ACKSEL_BIT = 8;
  localparam int ACKPOL_BIT = 7;
  localparam int EDGE_BIT   = 6;
  localparam int REQPOL_BIT = 5;

  typedef struct packed {
    logic autoReq;
    logic ackOnWrite;
    logic dackHigh;
    logic edgeMode;
    logic dreqHigh;
  } ctrlStrobe_t;
endpackage

// File: rtl/dra_ctrl.sv
module dra_ctrl
  import dra_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          standbyIn,
  input  logic                          modStopIn,
  input  logic                          cfgWe,
  input  logic [AUTO_BIT:REQPOL_BIT]    cfgWrData,
  output ctrlStrobe_t                   strobe
);
  logic [AUTO_BIT:REQPOL_BIT] cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (standbyIn) begin
      cfgReg <= '0;
    end else if (cfgWe && !modStopIn) begin
      cfgReg <= cfgWrData;
    end
  end

  always_comb begin
    strobe.autoReq    = cfgReg[AUTO_BIT];
    strobe.ackOnWrite = cfgReg[ACKSEL_BIT];
    strobe.dackHigh   = cfgReg[ACKPOL_BIT];
    strobe.edgeMode   = cfgReg[EDGE_BIT];
    strobe.dreqHigh   = cfgReg[REQPOL_BIT];
  end

  a_r11_standby_clear: assert property (@(posedge clk) disable iff (!rstN)
    standbyIn |=> (cfgReg == '0));

  a_r12_stop_holds: assert property (@(posedge clk) disable iff (!rstN)
    (modStopIn && !standbyIn) |=> $stable(cfgReg));
endmodule

// File: rtl/dra_dpath.sv
module dra_dpath
  import dra_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        chanEn,
  input  logic        dreqPin,
  input  logic        serReq,
  input  logic        rdPhase,
  input  logic        wrPhase,
  input  logic        singleAddr,
  output logic        xferReq,
  output logic        dackPin,
  output logic        devToMem
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic reqActive;
  logic prevActive;
  logic edgePulse;
  logic pinReq;
  logic moduleReq;
  logic ackWanted;

  // Synchronizer chain for the asynchronous request pin.
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= dreqPin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else       syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  assign reqActive = strobe.dreqHigh ? syncQ[LAST] : ~syncQ[LAST];

  // Starts as "active" so no pulse can appear straight out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevActive <= 1'b1;
    else       prevActive <= reqActive;
  end

  assign edgePulse = reqActive & ~prevActive;
  assign pinReq    = strobe.edgeMode ? edgePulse : reqActive;
  assign moduleReq = pinReq | serReq;
  assign xferReq   = chanEn & (strobe.autoReq ? 1'b1 : moduleReq);

  always_comb begin
    if (singleAddr) ackWanted = rdPhase | wrPhase;
    else if (strobe.ackOnWrite) ackWanted = wrPhase;
    else ackWanted = rdPhase;
  end

  assign dackPin  = strobe.dackHigh ? ackWanted : ~ackWanted;
  assign devToMem = singleAddr & strobe.ackOnWrite;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> !edgePulse);

  a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> !xferReq);

  a_r8_dack_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!rdPhase && !wrPhase) |-> (dackPin == !strobe.dackHigh));

  a_r10_dual_no_dir: assert property (@(posedge clk) disable iff (!rstN)
    !singleAddr |-> !devToMem);

  a_r2_auto_follows_en: assert property (@(posedge clk) disable iff (!rstN)
    strobe.autoReq |-> (xferReq == chanEn));
endmodule

// File: rtl/dma_req_ack.sv
module dma_req_ack
  import dra_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       standbyIn,
  input  logic                       modStopIn,
  input  logic                       cfgWe,
  input  logic [AUTO_BIT:REQPOL_BIT] cfgWrData,
  input  logic                       chanEn,
  input  logic                       dreqPin,
  input  logic                       serReq,
  input  logic                       rdPhase,
  input  logic                       wrPhase,
  input  logic                       singleAddr,
  output logic                       xferReq,
  output logic                       dackPin,
  output logic                       devToMem
);
  ctrlStrobe_t strobe;

  dra_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .standbyIn (standbyIn),
    .modStopIn (modStopIn),
    .cfgWe     (cfgWe),
    .cfgWrData (cfgWrData),
    .strobe    (strobe)
  );

  dra_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .chanEn     (chanEn),
    .dreqPin    (dreqPin),
    .serReq     (serReq),
    .rdPhase    (rdPhase),
    .wrPhase    (wrPhase),
    .singleAddr (singleAddr),
    .xferReq    (xferReq),
    .dackPin    (dackPin),
    .devToMem   (devToMem)
  );
endmodule

// File: tb/sim_dma_req_ack.sv
module sim_dma_req_ack;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standbyIn = 1'b0, modStopIn = 1'b0, cfgWe = 1'b0;
  logic [9:5] cfgWrData = '0;
  logic chanEn = 1'b1, dreqPin = 1'b1, serReq = 1'b0;
  logic rdPhase = 1'b0, wrPhase = 1'b0, singleAddr = 1'b0;
  logic xferReq, dackPin, devToMem;

  typedef struct {
    logic  req;
    logic  ack;
    logic  dir;
    string tag;
  } item_t;

  item_t expQ[$];
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_req_ack u0 (
    .clk(clk), .rstN(rstN), .standbyIn(standbyIn), .modStopIn(modStopIn),
    .cfgWe(cfgWe), .cfgWrData(cfgWrData), .chanEn(chanEn), .dreqPin(dreqPin),
    .serReq(serReq), .rdPhase(rdPhase), .wrPhase(wrPhase),
    .singleAddr(singleAddr), .xferReq(xferReq), .dackPin(dackPin),
    .devToMem(devToMem)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectOut(input logic r, input logic a, input logic d, input string tag);
    item_t it;
    it.req = r; it.ack = a; it.dir = d; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  // Control bits: [9] auto, [8] ack phase / direction, [7] ack polarity,
  // [6] edge detect, [5] request polarity.
  task automatic writeCfg(input logic [9:5] v);
    cfgWe = 1'b1;
    cfgWrData = v;
    step(1);
    cfgWe = 1'b0;
  endtask

  // Monitor: compare queued expectations away from the rising edge.
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nChecks++;
      if (xferReq !== it.req || dackPin !== it.ack || devToMem !== it.dir) begin
        nFails++;
        $display("FAIL %s: got req=%b ack=%b dir=%b expected req=%b ack=%b dir=%b",
                 it.tag, xferReq, dackPin, devToMem, it.req, it.ack, it.dir);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(3);
    expectOut(0, 1, 0, "R1 reset state");

    // R6: serial strobe, R7: enable gate
    serReq = 1'b1; #1;
    expectOut(1, 1, 0, "R6 serial request");
    chanEn = 1'b0; #1;
    expectOut(0, 1, 0, "R7 enable gates serial");
    chanEn = 1'b1; serReq = 1'b0; #1;

    // R3 level detect, active low (R5 polarity 0)
    dreqPin = 1'b0;
    step(1); expectOut(0, 1, 0, "R3 level not before 2 edges");
    step(1); expectOut(1, 1, 0, "R3 level rises after 2 edges");
    step(3); expectOut(1, 1, 0, "R3 level held");
    dreqPin = 1'b1;
    step(1); expectOut(1, 1, 0, "R3 level still high 1 edge after");
    step(1); expectOut(0, 1, 0, "R3 level falls after 2 edges");

    // R5 active high
    writeCfg(5'b00001);
    expectOut(1, 1, 0, "R5 active-high pin high");
    dreqPin = 1'b0;
    step(2); expectOut(0, 1, 0, "R5 active-high pin low");

    // R4 edge detect, active high
    writeCfg(5'b00011);
    dreqPin = 1'b1;
    step(1); expectOut(0, 1, 0, "R4 edge before 2 edges");
    step(1); expectOut(1, 1, 0, "R4 edge pulse");
    step(1); expectOut(0, 1, 0, "R4 pulse one cycle");
    step(3); expectOut(0, 1, 0, "R4 no repeat while held");
    dreqPin = 1'b0;
    step(3); expectOut(0, 1, 0, "R4 leaving level no pulse");

    // R4/R5 edge detect, active low
    dreqPin = 1'b1;
    step(3);
    writeCfg(5'b00010);
    expectOut(0, 1, 0, "R5 edge active-low idle");
    dreqPin = 1'b0;
    step(1); expectOut(0, 1, 0, "R4 low edge before 2 edges");
    step(1); expectOut(1, 1, 0, "R4 low edge pulse");
    step(1); expectOut(0, 1, 0, "R4 low pulse one cycle");

    // R2 auto request
    writeCfg(5'b10000);
    expectOut(1, 1, 0, "R2 auto request");
    dreqPin = 1'b1;
    step(3); expectOut(1, 1, 0, "R2 auto ignores pin");
    chanEn = 1'b0; #1;
    expectOut(0, 1, 0, "R7 enable gates auto");
    chanEn = 1'b1; #1;

    // R9 dual mode acknowledge timing, R8 polarity
    writeCfg(5'b00000);
    rdPhase = 1'b1; #1;
    expectOut(0, 0, 0, "R9 ack in read phase");
    rdPhase = 1'b0; wrPhase = 1'b1; #1;
    expectOut(0, 1, 0, "R9 no ack in write phase");
    wrPhase = 1'b0;
    writeCfg(5'b01000);
    wrPhase = 1'b1; #1;
    expectOut(0, 0, 0, "R9 ack in write phase");
    wrPhase = 1'b0; rdPhase = 1'b1; #1;
    expectOut(0, 1, 0, "R9 no ack in read phase");
    rdPhase = 1'b0;
    writeCfg(5'b01100);
    expectOut(0, 0, 0, "R8 active-high idle low");
    wrPhase = 1'b1; #1;
    expectOut(0, 1, 0, "R8 active-high asserted");
    wrPhase = 1'b0;

    // R10 single-address mode
    singleAddr = 1'b1; #1;
    expectOut(0, 0, 1, "R10 direction device to memory");
    rdPhase = 1'b1; #1;
    expectOut(0, 1, 1, "R10 ack in read phase single");
    rdPhase = 1'b0;
    writeCfg(5'b00100);
    expectOut(0, 0, 0, "R10 direction memory to device");
    wrPhase = 1'b1; #1;
    expectOut(0, 1, 0, "R10 ack in write phase single");
    wrPhase = 1'b0; singleAddr = 1'b0;

    // R12 writes ignored under module stop
    writeCfg(5'b01100);
    modStopIn = 1'b1;
    writeCfg(5'b00000);
    modStopIn = 1'b0; #1;
    expectOut(0, 0, 0, "R12 polarity held");
    wrPhase = 1'b1; #1;
    expectOut(0, 1, 0, "R12 ack phase held");
    wrPhase = 1'b0;

    // R11 standby clears
    standbyIn = 1'b1;
    step(1);
    standbyIn = 1'b0; #1;
    expectOut(0, 1, 0, "R11 standby clears polarity");
    rdPhase = 1'b1; #1;
    expectOut(0, 0, 0, "R11 standby clears phase select");
    rdPhase = 1'b0;

    step(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule